// File: doc/BRIEF.md
# Status-Change Interrupt Register Bank

This block collects per-channel fault indications from two independent monitors, a loss-of-signal detector and an output-driver short-circuit monitor, and presents them to a host through a small byte-wide register bus. Each monitor owns three registers: a live view of the synchronized fault flags, a per-channel interrupt mask, and a sticky record of every status transition (rising or falling) seen since the record was last read.

A host reads the sticky record to learn which channels moved. That one read returns the record and empties it. A transition that lands in the same cycle as the emptying read is kept for the next read. One registered, active-high interrupt line is raised while any unmasked sticky bit of either monitor is set. The six registers sit at fixed byte addresses. Any other address reads as zero.

Top module: `chg_irq_regbank`

## Requirements
- R1: After reset every register reads 00h, `irq_o` is 0 and `bus_rdata_o` is 00h.
- R2: Address 04h returns the loss-of-signal flags and 05h the short-circuit flags, with channel n in bit n. Each flag passes through SYNC_STAGES flops first, so it shows the input from SYNC_STAGES cycles earlier.
- R3: Addresses 06h (loss-of-signal mask) and 07h (short-circuit mask) are read/write. Writing 1 to bit n enables channel n. Bits at and above NUM_CH read 0, and a mask changes only on a write to its own address.
- R4: Bit n of address 08h (loss-of-signal) or 09h (short-circuit) is set when that channel's synchronized flag changes in either direction. A bit never sets without a change.
- R5: A read of 08h or 09h returns the value held before the read and clears that whole register. The other source's register is not affected.
- R6: A status change that falls in the same cycle as the clearing read leaves its bit set afterwards.
- R7: `irq_o` is 1 one cycle after any bit that is set in a sticky register is also set in the matching mask, for either source. Otherwise it is 0.
- R8: Reads of any address other than 04h to 09h return 00h. Writes to 04h, 05h, 08h, 09h or to unmapped addresses change nothing.
- R9: `bus_rdata_o` updates one cycle after a cycle with `bus_rd_i` high and holds its value while no read is issued.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| los_i | input | NUM_CH | Raw loss-of-signal flags, one per channel |
| sc_i | input | NUM_CH | Raw driver short-circuit flags, one per channel |
| bus_rd_i | input | 1 | Read strobe, one cycle per access |
| bus_wr_i | input | 1 | Write strobe, one cycle per access |
| bus_addr_i | input | ADDR_W | Register byte address |
| bus_wdata_i | input | DATA_W | Write data |
| bus_rdata_o | output | DATA_W | Registered read data |
| irq_o | output | 1 | Combined registered interrupt |

## Verification
The bench builds the block with NUM_CH=6 and SYNC_STAGES=3 rather than the defaults. The narrower channel count makes the zero-filled upper bits of every register visible. The deeper synchronizer tests that status latency and change detection follow the stage parameter and not a fixed delay. A read strobe is timed to land exactly on the cycle a change is detected, which exercises the coincident clear-and-set case. A random phase mixes reads, writes and toggles against the reference model.

// File: rtl/chg_irq_pkg.sv
package chg_irq_pkg;

   typedef enum logic [2:0] {
      SEL_NONE,
      SEL_LOS_STAT,
      SEL_SC_STAT,
      SEL_LOS_MASK,
      SEL_SC_MASK,
      SEL_LOS_EVT,
      SEL_SC_EVT
   } reg_sel_e;

   localparam int unsigned NUM_SOURCES = 2;

endpackage

// File: rtl/chg_irq_sync.sv
module chg_irq_sync #(
   parameter int unsigned WIDTH  = 8,
   parameter int unsigned STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d_i,
   output logic [WIDTH-1:0] q_o
);

   localparam int unsigned LAST = STAGES - 1;

   if (STAGES < 2) begin : g_bad_stages
      $error("chg_irq_sync: STAGES must be at least 2");
   end

   logic [WIDTH-1:0] stg_q [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int k = 0; k < STAGES; k++) stg_q[k] <= '0;
      end else begin
         stg_q[0] <= d_i;
         for (int k = 1; k < STAGES; k++) stg_q[k] <= stg_q[k-1];
      end
   end

   assign q_o = stg_q[LAST];

endmodule

// File: rtl/chg_irq_decode.sv
module chg_irq_decode
   import chg_irq_pkg::*;
#(
   parameter int unsigned    ADDR_W        = 8,
   parameter logic [ADDR_W-1:0] LOS_STAT_ADDR = 'h04,
   parameter logic [ADDR_W-1:0] SC_STAT_ADDR  = 'h05,
   parameter logic [ADDR_W-1:0] LOS_MASK_ADDR = 'h06,
   parameter logic [ADDR_W-1:0] SC_MASK_ADDR  = 'h07,
   parameter logic [ADDR_W-1:0] LOS_EVT_ADDR  = 'h08,
   parameter logic [ADDR_W-1:0] SC_EVT_ADDR   = 'h09
) (
   input  logic [ADDR_W-1:0] addr_i,
   output reg_sel_e          sel_o
);

   always_comb begin
      if      (addr_i == LOS_STAT_ADDR) sel_o = SEL_LOS_STAT;
      else if (addr_i == SC_STAT_ADDR)  sel_o = SEL_SC_STAT;
      else if (addr_i == LOS_MASK_ADDR) sel_o = SEL_LOS_MASK;
      else if (addr_i == SC_MASK_ADDR)  sel_o = SEL_SC_MASK;
      else if (addr_i == LOS_EVT_ADDR)  sel_o = SEL_LOS_EVT;
      else if (addr_i == SC_EVT_ADDR)   sel_o = SEL_SC_EVT;
      else                              sel_o = SEL_NONE;
   end

endmodule

// File: rtl/chg_irq_source.sv
module chg_irq_source #(
   parameter int unsigned NUM_CH      = 8,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NUM_CH-1:0] flag_i,
   input  logic              mask_we_i,
   input  logic [NUM_CH-1:0] mask_wdata_i,
   input  logic              evt_clr_i,
   output logic [NUM_CH-1:0] stat_o,
   output logic [NUM_CH-1:0] mask_o,
   output logic [NUM_CH-1:0] evt_o,
   output logic              pend_o
);

   logic [NUM_CH-1:0] sync_w;
   logic [NUM_CH-1:0] prev_q;
   logic [NUM_CH-1:0] chg_w;
   logic [NUM_CH-1:0] evt_q;
   logic [NUM_CH-1:0] mask_q;

   chg_irq_sync #(
      .WIDTH  (NUM_CH),
      .STAGES (SYNC_STAGES)
   ) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   (flag_i),
      .q_o   (sync_w)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= '0;
      else        prev_q <= sync_w;
   end

   assign chg_w = sync_w ^ prev_q;

   for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_evt
      logic bit_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)         bit_q <= 1'b0;
         else if (chg_w[ch]) bit_q <= 1'b1;
         else if (evt_clr_i) bit_q <= 1'b0;
      end
      assign evt_q[ch] = bit_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         mask_q <= '0;
      else if (mask_we_i) mask_q <= mask_wdata_i;
   end

   assign stat_o = sync_w;
   assign mask_o = mask_q;
   assign evt_o  = evt_q;
   assign pend_o = |(evt_q & mask_q);

   // R4: a detected change always shows in the sticky register next cycle
   a_r4_change_sets: assert property (@(posedge clk) disable iff (!rst_n)
      (chg_w != '0) |=> ((evt_q & $past(chg_w)) == $past(chg_w)));

   // R4: without a change no sticky bit rises
   a_r4_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
      (chg_w == '0) |=> ((evt_q & ~$past(evt_q)) == '0));

   // R5: a clearing read with no concurrent change empties the register
   a_r5_clear_all: assert property (@(posedge clk) disable iff (!rst_n)
      (evt_clr_i && chg_w == '0) |=> (evt_q == '0));

   // R6: a change coincident with the clear survives it
   a_r6_keep_event: assert property (@(posedge clk) disable iff (!rst_n)
      (evt_clr_i && chg_w != '0) |=> (evt_q == $past(chg_w)));

   // R3: the mask moves only on its own write
   a_r3_mask_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !mask_we_i |=> $stable(mask_q));

endmodule

// File: rtl/chg_irq_regbank.sv
module chg_irq_regbank
   import chg_irq_pkg::*;
#(
   parameter int unsigned NUM_CH      = 8,
   parameter int unsigned DATA_W      = 8,
   parameter int unsigned ADDR_W      = 8,
   parameter int unsigned SYNC_STAGES = 2,
   parameter logic [ADDR_W-1:0] LOS_STAT_ADDR = 'h04,
   parameter logic [ADDR_W-1:0] SC_STAT_ADDR  = 'h05,
   parameter logic [ADDR_W-1:0] LOS_MASK_ADDR = 'h06,
   parameter logic [ADDR_W-1:0] SC_MASK_ADDR  = 'h07,
   parameter logic [ADDR_W-1:0] LOS_EVT_ADDR  = 'h08,
   parameter logic [ADDR_W-1:0] SC_EVT_ADDR   = 'h09
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NUM_CH-1:0] los_i,
   input  logic [NUM_CH-1:0] sc_i,
   input  logic              bus_rd_i,
   input  logic              bus_wr_i,
   input  logic [ADDR_W-1:0] bus_addr_i,
   input  logic [DATA_W-1:0] bus_wdata_i,
   output logic [DATA_W-1:0] bus_rdata_o,
   output logic              irq_o
);

   localparam int unsigned NSRC = NUM_SOURCES;
   localparam int unsigned PADW = DATA_W - NUM_CH;

   if (NUM_CH < 1 || NUM_CH > DATA_W) begin : g_bad_ch
      $error("chg_irq_regbank: NUM_CH must be within 1..DATA_W");
   end
   if (LOS_STAT_ADDR == SC_STAT_ADDR || LOS_STAT_ADDR == LOS_MASK_ADDR ||
       LOS_STAT_ADDR == SC_MASK_ADDR || LOS_STAT_ADDR == LOS_EVT_ADDR ||
       LOS_STAT_ADDR == SC_EVT_ADDR  || SC_STAT_ADDR  == LOS_MASK_ADDR ||
       SC_STAT_ADDR  == SC_MASK_ADDR || SC_STAT_ADDR  == LOS_EVT_ADDR  ||
       SC_STAT_ADDR  == SC_EVT_ADDR  || LOS_MASK_ADDR == SC_MASK_ADDR  ||
       LOS_MASK_ADDR == LOS_EVT_ADDR || LOS_MASK_ADDR == SC_EVT_ADDR   ||
       SC_MASK_ADDR  == LOS_EVT_ADDR || SC_MASK_ADDR  == SC_EVT_ADDR   ||
       LOS_EVT_ADDR  == SC_EVT_ADDR) begin : g_bad_map
      $error("chg_irq_regbank: register addresses must be distinct");
   end

   reg_sel_e sel_w;

   chg_irq_decode #(
      .ADDR_W        (ADDR_W),
      .LOS_STAT_ADDR (LOS_STAT_ADDR),
      .SC_STAT_ADDR  (SC_STAT_ADDR),
      .LOS_MASK_ADDR (LOS_MASK_ADDR),
      .SC_MASK_ADDR  (SC_MASK_ADDR),
      .LOS_EVT_ADDR  (LOS_EVT_ADDR),
      .SC_EVT_ADDR   (SC_EVT_ADDR)
   ) u_decode (
      .addr_i (bus_addr_i),
      .sel_o  (sel_w)
   );

   logic [NUM_CH-1:0] flag_w  [NSRC];
   logic [NUM_CH-1:0] stat_w  [NSRC];
   logic [NUM_CH-1:0] mask_w  [NSRC];
   logic [NUM_CH-1:0] evt_w   [NSRC];
   logic              pend_w  [NSRC];
   logic              we_w    [NSRC];
   logic              clr_w   [NSRC];

   assign flag_w[0] = los_i;
   assign flag_w[1] = sc_i;
   assign we_w[0]   = bus_wr_i && (sel_w == SEL_LOS_MASK);
   assign we_w[1]   = bus_wr_i && (sel_w == SEL_SC_MASK);
   assign clr_w[0]  = bus_rd_i && (sel_w == SEL_LOS_EVT);
   assign clr_w[1]  = bus_rd_i && (sel_w == SEL_SC_EVT);

   for (genvar s = 0; s < NSRC; s++) begin : g_src
      chg_irq_source #(
         .NUM_CH      (NUM_CH),
         .SYNC_STAGES (SYNC_STAGES)
      ) u_src (
         .clk          (clk),
         .rst_n        (rst_n),
         .flag_i       (flag_w[s]),
         .mask_we_i    (we_w[s]),
         .mask_wdata_i (bus_wdata_i[NUM_CH-1:0]),
         .evt_clr_i    (clr_w[s]),
         .stat_o       (stat_w[s]),
         .mask_o       (mask_w[s]),
         .evt_o        (evt_w[s]),
         .pend_o       (pend_w[s])
      );
   end

   logic [NUM_CH-1:0] rd_raw_w;
   logic [DATA_W-1:0] rd_byte_w;
   logic              pend_any_w;
   logic [DATA_W-1:0] rdata_q;
   logic              irq_q;

   always_comb begin
      unique case (sel_w)
         SEL_LOS_STAT: rd_raw_w = stat_w[0];
         SEL_SC_STAT:  rd_raw_w = stat_w[1];
         SEL_LOS_MASK: rd_raw_w = mask_w[0];
         SEL_SC_MASK:  rd_raw_w = mask_w[1];
         SEL_LOS_EVT:  rd_raw_w = evt_w[0];
         SEL_SC_EVT:   rd_raw_w = evt_w[1];
         default:      rd_raw_w = '0;
      endcase
   end

   if (PADW == 0) begin : g_nopad
      assign rd_byte_w = rd_raw_w;
   end else begin : g_pad
      assign rd_byte_w = {{PADW{1'b0}}, rd_raw_w};
   end

   always_comb begin
      pend_any_w = 1'b0;
      for (int s = 0; s < NSRC; s++) pend_any_w = pend_any_w | pend_w[s];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        rdata_q <= '0;
      else if (bus_rd_i) rdata_q <= rd_byte_w;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) irq_q <= 1'b0;
      else        irq_q <= pend_any_w;
   end

   assign bus_rdata_o = rdata_q;
   assign irq_o       = irq_q;

   // R9: read data holds between reads
   a_r9_rdata_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_rd_i |=> $stable(bus_rdata_o));

   // R8: an unmapped read returns zero
   a_r8_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rd_i && sel_w == SEL_NONE) |=> (bus_rdata_o == '0));

   // R7: the line rises only from an unmasked pending event
   a_r7_irq_source: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq_o) |-> $past(pend_w[0] || pend_w[1]));

   // R7: with nothing pending the line drops next cycle
   a_r7_irq_drop: assert property (@(posedge clk) disable iff (!rst_n)
      !(pend_w[0] || pend_w[1]) |=> !irq_o);

endmodule

// File: tb/chg_irq_regbank_tb_top.sv
module chg_irq_regbank_tb_top;

   localparam int NCH  = 6;
   localparam int SYNC = 3;

   logic           clk = 1'b0;
   logic           rst_n = 1'b0;
   logic [NCH-1:0] los_in = '0;
   logic [NCH-1:0] sc_in = '0;
   logic           rd = 1'b0;
   logic           wr = 1'b0;
   logic [7:0]     addr = 8'h00;
   logic [7:0]     wdata = 8'h00;
   logic [7:0]     rdata;
   logic           irq;

   int errors = 0;
   int checks = 0;
   string cur_req = "R1";

   always #4 clk = ~clk;

   chg_irq_regbank #(
      .NUM_CH      (NCH),
      .SYNC_STAGES (SYNC)
   ) dut_i (
      .clk         (clk),
      .rst_n       (rst_n),
      .los_i       (los_in),
      .sc_i        (sc_in),
      .bus_rd_i    (rd),
      .bus_wr_i    (wr),
      .bus_addr_i  (addr),
      .bus_wdata_i (wdata),
      .bus_rdata_o (rdata),
      .irq_o       (irq)
   );

   // behavioural reference state
   logic [NCH-1:0] m_stg  [2][SYNC];
   logic [NCH-1:0] m_prev [2];
   logic [NCH-1:0] m_evt  [2];
   logic [NCH-1:0] m_mask [2];
   logic [7:0]     m_rdata;
   logic           m_irq;

   task automatic model_reset();
      for (int k = 0; k < 2; k++) begin
         for (int j = 0; j < SYNC; j++) m_stg[k][j] = '0;
         m_prev[k] = '0; m_evt[k] = '0; m_mask[k] = '0;
      end
      m_rdata = 8'h00; m_irq = 1'b0;
   endtask

   function automatic logic [7:0] model_read(logic [7:0] a);
      case (a)
         8'h04:   return 8'(m_stg[0][SYNC-1]);
         8'h05:   return 8'(m_stg[1][SYNC-1]);
         8'h06:   return 8'(m_mask[0]);
         8'h07:   return 8'(m_mask[1]);
         8'h08:   return 8'(m_evt[0]);
         8'h09:   return 8'(m_evt[1]);
         default: return 8'h00;
      endcase
   endfunction

   task automatic model_step();
      logic [NCH-1:0] cur [2];
      logic [NCH-1:0] chg [2];
      logic           pend;
      logic           clr [2];
      for (int k = 0; k < 2; k++) begin
         cur[k] = m_stg[k][SYNC-1];
         chg[k] = cur[k] ^ m_prev[k];
      end
      pend = ((m_evt[0] & m_mask[0]) != '0) || ((m_evt[1] & m_mask[1]) != '0);
      clr[0] = rd && addr == 8'h08;
      clr[1] = rd && addr == 8'h09;
      if (rd) m_rdata = model_read(addr);
      for (int k = 0; k < 2; k++) begin
         m_evt[k]  = (clr[k] ? '0 : m_evt[k]) | chg[k];
         m_prev[k] = cur[k];
         for (int j = SYNC - 1; j > 0; j--) m_stg[k][j] = m_stg[k][j-1];
      end
      m_stg[0][0] = los_in;
      m_stg[1][0] = sc_in;
      if (wr && addr == 8'h06) m_mask[0] = wdata[NCH-1:0];
      if (wr && addr == 8'h07) m_mask[1] = wdata[NCH-1:0];
      m_irq = pend;
   endtask

   task automatic check8(string req, string what, logic [7:0] act, logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s actual=%02h expected=%02h", req, what, act, exp);
      end
   endtask

   task automatic check1(string req, string what, logic act, logic exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s actual=%0b expected=%0b", req, what, act, exp);
      end
   endtask

   // one clock: model follows the edge, outputs compared at the falling edge
   task automatic cycle();
      @(posedge clk);
      if (rst_n) model_step(); else model_reset();
      @(negedge clk);
      check8(cur_req, "rdata vs model", rdata, m_rdata);
      check1(cur_req, "irq vs model", irq, m_irq);
   endtask

   task automatic idle(int n);
      for (int i = 0; i < n; i++) cycle();
   endtask

   task automatic bus_write(logic [7:0] a, logic [7:0] d);
      wr = 1'b1; addr = a; wdata = d;
      cycle();
      wr = 1'b0; addr = 8'h00; wdata = 8'h00;
   endtask

   task automatic read_expect(string req, logic [7:0] a, logic [7:0] exp);
      rd = 1'b1; addr = a;
      cycle();
      rd = 1'b0; addr = 8'h00;
      check8(req, $sformatf("read %02h", a), rdata, exp);
   endtask

   bit done = 1'b0;

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL R9 watchdog actual=running expected=finished");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      model_reset();
      repeat (3) @(negedge clk);
      // R1: reset state
      cur_req = "R1";
      check8("R1", "rdata in reset", rdata, 8'h00);
      check1("R1", "irq in reset", irq, 1'b0);
      rst_n = 1'b1;
      idle(2);
      read_expect("R1", 8'h04, 8'h00);
      read_expect("R1", 8'h05, 8'h00);
      read_expect("R1", 8'h06, 8'h00);
      read_expect("R1", 8'h07, 8'h00);
      read_expect("R1", 8'h08, 8'h00);
      read_expect("R1", 8'h09, 8'h00);

      // R3: masks read/write, upper bits zero
      cur_req = "R3";
      bus_write(8'h06, 8'hFF);
      read_expect("R3", 8'h06, 8'h3F);
      bus_write(8'h07, 8'h05);
      read_expect("R3", 8'h07, 8'h05);
      read_expect("R3", 8'h06, 8'h3F);

      // R8: read-only and unmapped writes ignored, unmapped reads zero
      cur_req = "R8";
      bus_write(8'h04, 8'hFF);
      bus_write(8'h08, 8'hFF);
      bus_write(8'h0A, 8'hFF);
      read_expect("R8", 8'h04, 8'h00);
      read_expect("R8", 8'h08, 8'h00);
      read_expect("R8", 8'h0A, 8'h00);
      read_expect("R8", 8'hFF, 8'h00);
      read_expect("R8", 8'h07, 8'h05);

      // R9: read data holds while idle
      cur_req = "R9";
      read_expect("R9", 8'h06, 8'h3F);
      idle(4);
      check8("R9", "rdata hold", rdata, 8'h3F);

      // R2/R4/R7: rising loss-of-signal flags
      cur_req = "R2";
      los_in = 6'b000101;
      idle(SYNC + 2);
      check1("R7", "irq with unmasked event", irq, 1'b1);
      read_expect("R2", 8'h04, 8'h05);
      cur_req = "R4";
      read_expect("R4", 8'h08, 8'h05);
      cur_req = "R5";
      read_expect("R5", 8'h08, 8'h00);
      idle(1);
      check1("R7", "irq after clear", irq, 1'b0);

      // R4: falling flags also latch
      cur_req = "R4";
      los_in = 6'b000000;
      idle(SYNC + 2);
      read_expect("R4", 8'h08, 8'h05);
      read_expect("R2", 8'h04, 8'h00);

      // R7: masked short-circuit event keeps irq low
      cur_req = "R7";
      sc_in = 6'b100000;
      idle(SYNC + 2);
      check1("R7", "irq with masked event", irq, 1'b0);
      read_expect("R2", 8'h05, 8'h20);
      sc_in = 6'b100001;
      idle(SYNC + 2);
      check1("R7", "irq with unmasked short event", irq, 1'b1);

      // R5: clearing one source leaves the other
      cur_req = "R5";
      los_in = 6'b000010;
      idle(SYNC + 2);
      read_expect("R5", 8'h09, 8'h21);
      read_expect("R5", 8'h09, 8'h00);
      read_expect("R5", 8'h08, 8'h02);

      // R6: change on the same edge as the clearing read
      cur_req = "R6";
      los_in = 6'b010010;
      idle(SYNC);
      read_expect("R6", 8'h08, 8'h00);
      read_expect("R6", 8'h08, 8'h10);

      // mixed traffic against the model
      cur_req = "R9";
      for (int i = 0; i < 400; i++) begin
         logic [2:0] op = 3'($urandom_range(0, 7));
         logic [7:0] a;
         case ($urandom_range(0, 7))
            0: a = 8'h04; 1: a = 8'h05; 2: a = 8'h06; 3: a = 8'h07;
            4: a = 8'h08; 5: a = 8'h09; 6: a = 8'h0B; default: a = 8'h00;
         endcase
         if (op[0]) los_in = los_in ^ 6'($urandom_range(0, 63) & 6'h11);
         if (op[1]) sc_in  = sc_in  ^ 6'($urandom_range(0, 63) & 6'h22);
         rd = (op == 3'd3) || (op == 3'd5) || (op == 3'd7);
         wr = (op == 3'd4) || (op == 3'd7);
         addr = a;
         wdata = 8'($urandom_range(0, 255));
         cycle();
         rd = 1'b0; wr = 1'b0;
      end
      idle(SYNC + 3);

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule